// File: doc/BRIEF.md
# Prioritized Banked Interrupt Controller

The block collects up to 96 level-sensitive peripheral interrupt lines, split into banks of 32, and presents them to a processor as two request outputs: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Each line has an enable bit and a routing bit that sends it to one of the two outputs. Software reads the raw masked status, the per-output pending status, and a single word that names the most urgent pending normal interrupt.

Urgency comes from a programmable table, not from the line number. Each table slot stands for one priority level, with level 0 the most urgent. A slot names a source and carries a valid flag. The arbiter walks the levels upward and picks the first valid slot whose source is pending on the normal output. The result is registered. A control bit selects whether any raw line or only an enabled line drives the idle-wake output.

All registers sit on a simple single-cycle bus. Writes are captured on the clock edge. Read data is combinational from the address, and it reads zero when `bus_en_i` is low or the address is not mapped.

Top module: `prio_intc`

## Requirements
- R1: After reset, all enable bits, routing bits, the wake-control bit and every priority slot read 0; `irq_o`, `fiq_o` and `wake_o` are low while no source is high; and the winner word reads 0.
- R2: The status register at bank offset 0x00 reads source line AND enable bit. The enable register is at bank offset 0x04, and a 1 enables the source.
- R3: The routing register is at bank offset 0x08. A routing bit of 0 places an enabled, high source in the normal-pending register (offset 0x10) and on `irq_o`. A 1 places it in the fast-pending register (offset 0x0C) and on `fiq_o`. Both outputs follow in the same cycle.
- R4: The bank bases are 0x000, 0x09C and 0x130. Source n sits at bit n mod 32 of the bank n div 32.
- R5: The status, fast-pending, normal-pending and winner registers cannot be written: a write of all ones leaves their readback unchanged. A status bit follows its line high and low.
- R6: Priority slot i is at 0x01C+4i for i<32, at 0x0B0+4(i-32) for i<64, and at 0x144+4(i-64) otherwise. It stores a source number in bits 6:0 and a valid flag in bit 31. All other bits read 0.
- R7: The winner word at 0x018 has bit 31 set and the source number in bits 30:16 for the lowest-numbered valid slot whose source is enabled, high and routed to the normal output. It reads 0 when no slot qualifies. Invalid slots, disabled sources and fast-routed sources never win.
- R8: The winner word changes exactly one clock edge after the inputs it depends on change.
- R9: The wake-control bit is bit 0 at 0x014. When it is 1, `wake_o` is the OR of the enabled, high sources. When it is 0, `wake_o` is the OR of all raw lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 96 | Level-sensitive interrupt lines |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 10 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle-wake request |

## Verification
Some properties are checked on every cycle by assertions. A write to the enable, routing or wake-control register must land on the next edge. `irq_o` never rises without some line high. `wake_o` follows any raw line while the control bit is clear. A valid winner implies that some normal-pending source existed one cycle earlier, and the winner word holds when its inputs hold. Other behaviour can only be shown by the directed scenarios: the irregular bank and slot addresses, the level-ordered choice of the winner as entries are masked, rerouted and invalidated, the one-cycle winner latency, and the immunity of the status registers to writes.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int BANK_W    = 32;
  localparam int MAX_BANKS = 3;
  localparam int ADDR_W    = 10;
  localparam int DATA_W    = 32;

  // per-bank register offsets
  localparam int OFF_PEND  = 'h00;
  localparam int OFF_MASK  = 'h04;
  localparam int OFF_STEER = 'h08;
  localparam int OFF_FIQ   = 'h0C;
  localparam int OFF_IRQ   = 'h10;
  // bank 0 only
  localparam int OFF_CTRL  = 'h14;
  localparam int OFF_WIN   = 'h18;

  localparam int WIN_VALID_BIT = 31;
  localparam int WIN_SRC_LSB   = 16;
  localparam int WIN_SRC_W     = 15;
  localparam int SLOT_VALID_BIT = 31;

  function automatic logic [ADDR_W-1:0] bank_base(input int b);
    case (b)
      0:       return ADDR_W'('h000);
      1:       return ADDR_W'('h09C);
      default: return ADDR_W'('h130);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] reg_addr(input int b, input int off);
    return bank_base(b) + ADDR_W'(off);
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input int i);
    if (i < 32)      return ADDR_W'('h01C + 4 * i);
    else if (i < 64) return ADDR_W'('h0B0 + 4 * (i - 32));
    else             return ADDR_W'('h144 + 4 * (i - 64));
  endfunction
endpackage

// File: rtl/prio_intc_bank.sv
module prio_intc_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] src_i,
  input  logic              mask_we_i,
  input  logic              steer_we_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] steer_o,
  output logic [BANK_W-1:0] pend_o,
  output logic [BANK_W-1:0] irq_pend_o,
  output logic [BANK_W-1:0] fiq_pend_o
);
  logic [BANK_W-1:0] mask_q, steer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      steer_q <= '0;
    end else begin
      if (mask_we_i)  mask_q  <= wdata_i;
      if (steer_we_i) steer_q <= wdata_i;
    end
  end

  assign mask_o     = mask_q;
  assign steer_o    = steer_q;
  assign pend_o     = src_i & mask_q;
  assign irq_pend_o = pend_o & ~steer_q;
  assign fiq_pend_o = pend_o & steer_q;

  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_o == $past(wdata_i)); // R2
  AST_STEER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steer_we_i |=> steer_o == $past(wdata_i)); // R3
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb #(
  parameter int NUM_SRC = 96,
  parameter int SRC_W   = 7
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SRC-1:0]             irq_pend_i,
  input  logic [NUM_SRC-1:0]             slot_valid_i,
  input  logic [NUM_SRC-1:0][SRC_W-1:0]  slot_src_i,
  output logic                           win_valid_o,
  output logic [SRC_W-1:0]               win_src_o
);
  logic             hit;
  logic [SRC_W-1:0] hit_src;

  // scan from the least urgent level down so the lowest level overrides
  always_comb begin
    hit     = 1'b0;
    hit_src = '0;
    for (int l = NUM_SRC - 1; l >= 0; l--) begin
      if (slot_valid_i[l] && (int'(slot_src_i[l]) < NUM_SRC)) begin
        if (irq_pend_i[slot_src_i[l]]) begin
          hit     = 1'b1;
          hit_src = slot_src_i[l];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_valid_o <= 1'b0;
      win_src_o   <= '0;
    end else begin
      win_valid_o <= hit;
      win_src_o   <= hit ? hit_src : '0;
    end
  end

  AST_WIN_HAS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> $past(|irq_pend_i)); // R7
  AST_WIN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(irq_pend_i) && $stable(slot_valid_i) && $stable(slot_src_i))
      |=> ($stable(win_valid_o) && $stable(win_src_o))); // R8
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_BANKS = MAX_BANKS
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_BANKS*BANK_W-1:0]    src_i,
  input  logic                           bus_en_i,
  input  logic                           bus_we_i,
  input  logic [ADDR_W-1:0]              bus_addr_i,
  input  logic [DATA_W-1:0]              bus_wdata_i,
  output logic [DATA_W-1:0]              bus_rdata_o,
  output logic                           irq_o,
  output logic                           fiq_o,
  output logic                           wake_o
);
  localparam int NUM_SRC = NUM_BANKS * BANK_W;
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int PAD_W   = DATA_W - 1 - SRC_W;

  logic wr_en;
  assign wr_en = bus_en_i & bus_we_i;

  logic [NUM_BANKS-1:0][BANK_W-1:0] mask, steer, pend, irq_pend, fiq_pend;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic mask_we, steer_we;
    assign mask_we  = wr_en && (bus_addr_i == reg_addr(b, OFF_MASK));
    assign steer_we = wr_en && (bus_addr_i == reg_addr(b, OFF_STEER));

    prio_intc_bank #(.BANK_W(BANK_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_i[b*BANK_W +: BANK_W]),
      .mask_we_i  (mask_we),
      .steer_we_i (steer_we),
      .wdata_i    (bus_wdata_i[BANK_W-1:0]),
      .mask_o     (mask[b]),
      .steer_o    (steer[b]),
      .pend_o     (pend[b]),
      .irq_pend_o (irq_pend[b]),
      .fiq_pend_o (fiq_pend[b])
    );
  end

  // wake control, bank 0 only
  logic ctrl_q, ctrl_we;
  assign ctrl_we = wr_en && (bus_addr_i == reg_addr(0, OFF_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= 1'b0;
    else if (ctrl_we) ctrl_q <= bus_wdata_i[0];
  end

  // priority table: slot = level
  logic [NUM_SRC-1:0]            slot_valid_q;
  logic [NUM_SRC-1:0][SRC_W-1:0] slot_src_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (bus_addr_i == slot_addr(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_valid_q[i] <= 1'b0;
        slot_src_q[i]   <= '0;
      end else if (slot_we) begin
        slot_valid_q[i] <= bus_wdata_i[SLOT_VALID_BIT];
        slot_src_q[i]   <= bus_wdata_i[SRC_W-1:0];
      end
    end
  end

  logic             win_valid;
  logic [SRC_W-1:0] win_src;

  prio_intc_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_pend_i   (irq_pend),
    .slot_valid_i (slot_valid_q),
    .slot_src_i   (slot_src_q),
    .win_valid_o  (win_valid),
    .win_src_o    (win_src)
  );

  assign irq_o  = |irq_pend;
  assign fiq_o  = |fiq_pend;
  assign wake_o = ctrl_q ? (|pend) : (|src_i);

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (bus_en_i && !bus_we_i) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bus_addr_i == reg_addr(b, OFF_PEND))  bus_rdata_o = pend[b];
        if (bus_addr_i == reg_addr(b, OFF_MASK))  bus_rdata_o = mask[b];
        if (bus_addr_i == reg_addr(b, OFF_STEER)) bus_rdata_o = steer[b];
        if (bus_addr_i == reg_addr(b, OFF_FIQ))   bus_rdata_o = fiq_pend[b];
        if (bus_addr_i == reg_addr(b, OFF_IRQ))   bus_rdata_o = irq_pend[b];
      end
      if (bus_addr_i == reg_addr(0, OFF_CTRL))
        bus_rdata_o = {{(DATA_W-1){1'b0}}, ctrl_q};
      if (bus_addr_i == reg_addr(0, OFF_WIN))
        bus_rdata_o = {win_valid, WIN_SRC_W'(win_src), {WIN_SRC_LSB{1'b0}}};
      for (int i = 0; i < NUM_SRC; i++) begin
        if (bus_addr_i == slot_addr(i))
          bus_rdata_o = {slot_valid_q[i], {PAD_W{1'b0}}, slot_src_q[i]};
      end
    end
  end

  AST_IRQ_NEEDS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|src_i)); // R3
  AST_WAKE_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q && (|src_i)) |-> wake_o); // R9
  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we |=> ctrl_q == $past(bus_wdata_i[0])); // R9
endmodule

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] src = '0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, fiq, wake;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_intc u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 check(req, bus_rdata, exp);
  endtask

  task automatic pin_chk(input string req, input logic act, input logic exp);
    @(negedge clk);
    #1 check(req, {31'b0, act}, {31'b0, exp});
  endtask

  function automatic logic [31:0] win(input int s);
    return 32'h8000_0000 | (s << 16);
  endfunction

  task automatic t_reset;
    rd_chk("R1 mask0", 10'h004, 0);
    rd_chk("R1 steer0", 10'h008, 0);
    rd_chk("R1 mask2", 10'h134, 0);
    rd_chk("R1 ctrl", 10'h014, 0);
    rd_chk("R1 win", 10'h018, 0);
    rd_chk("R1 slot0", 10'h01C, 0);
    pin_chk("R1 irq_o", irq, 0);
    pin_chk("R1 fiq_o", fiq, 0);
    pin_chk("R1 wake_o", wake, 0);
  endtask

  task automatic t_mask_pending;
    src[5] = 1'b1; src[40] = 1'b1;
    wr(10'h004, 32'h20);
    rd_chk("R2 pend bank0", 10'h000, 32'h20);
    rd_chk("R2 bank1 masked", 10'h09C, 0);
    wr(10'h0A0, 32'h100);
    rd_chk("R4 pend bank1", 10'h09C, 32'h100);
    rd_chk("R4 irq bank1", 10'h0AC, 32'h100);
    pin_chk("R3 irq_o", irq, 1);
  endtask

  task automatic t_steer;
    wr(10'h008, 32'h20);
    rd_chk("R3 fiq reg", 10'h00C, 32'h20);
    rd_chk("R3 irq reg", 10'h010, 0);
    pin_chk("R3 fiq_o", fiq, 1);
    wr(10'h0A0, 0);
    pin_chk("R3 irq_o off", irq, 0);
    wr(10'h0A0, 32'h100);
    src[70] = 1'b1;
    wr(10'h134, 32'h40);
    rd_chk("R4 pend bank2", 10'h130, 32'h40);
    rd_chk("R4 irq bank2", 10'h140, 32'h40);
    rd_chk("R4 fiq bank2", 10'h13C, 0);
  endtask

  task automatic t_readonly;
    wr(10'h000, 32'hFFFF_FFFF);
    rd_chk("R5 pend ro", 10'h000, 32'h20);
    wr(10'h010, 32'hFFFF_FFFF);
    rd_chk("R5 irq ro", 10'h010, 0);
    wr(10'h00C, 32'hFFFF_FFFF);
    rd_chk("R5 fiq ro", 10'h00C, 32'h20);
    wr(10'h018, 32'hFFFF_FFFF);
    rd_chk("R5 win ro", 10'h018, 0);
    @(negedge clk) src[5] = 1'b0;
    rd_chk("R5 level low", 10'h000, 0);
    @(negedge clk) src[5] = 1'b1;
    rd_chk("R5 level high", 10'h000, 32'h20);
  endtask

  task automatic t_prio;
    wr(10'h01C, 32'h8000_0000 | 70);
    wr(10'h020, 32'h8000_0000 | 5);
    wr(10'h0B0, 32'h8000_0000 | 40);
    rd_chk("R6 slot32", 10'h0B0, 32'h8000_0028);
    rd_chk("R6 slot64 reset", 10'h144, 0);
    wr(10'h144, 32'h7FFF_FF03);
    rd_chk("R6 slot64 bits", 10'h144, 32'h0000_0003);
    rd_chk("R7 win level0", 10'h018, win(70));
    wr(10'h134, 0);
    rd_chk("R7 skip masked+fiq", 10'h018, win(40));
    wr(10'h008, 0);
    rd_chk("R7 level1 irq", 10'h018, win(5));
    wr(10'h020, 32'd5);
    rd_chk("R7 invalid slot", 10'h018, win(40));
  endtask

  task automatic t_latency;
    @(negedge clk);
    src[40] = 1'b0; bus_en = 1'b1; bus_we = 1'b0; bus_addr = 10'h018;
    #1 check("R8 old winner held", bus_rdata, win(40));
    @(negedge clk);
    #1 check("R8 cleared after edge", bus_rdata, 0);
    src[40] = 1'b1;
    #1 check("R8 rise not yet", bus_rdata, 0);
    @(negedge clk);
    #1 check("R8 rise after edge", bus_rdata, win(40));
  endtask

  task automatic t_wake;
    pin_chk("R9 raw wake", wake, 1);
    @(negedge clk) begin src = '0; src[90] = 1'b1; end
    pin_chk("R9 raw masked line", wake, 1);
    wr(10'h014, 32'h1);
    rd_chk("R9 ctrl readback", 10'h014, 1);
    pin_chk("R9 masked no wake", wake, 0);
    wr(10'h134, 32'h0400_0000);
    pin_chk("R9 unmasked wake", wake, 1);
    pin_chk("R3 irq bank2 bit26", irq, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mask_pending();
    t_steer();
    t_readonly();
    t_prio();
    t_latency();
    t_wake();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule